// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit with Saturation and Store Rounding

This block is a single-cycle multiply-accumulate datapath for fractional fixed-point signal processing. Two signed fractional operands are multiplied each cycle. The product is realigned to drop its duplicate sign bit and then added to, or subtracted from, a wide accumulator. The accumulator carries guard bits above the product, so a long run of filter taps can build up without wrapping.

The accumulator can instead start from the new product, which clears the previous sum. A saturation enable chooses how overflow is handled, both in the accumulator and when the sum is narrowed to a data word. When it is off, results wrap. When it is on, results clamp to the most positive or most negative value.

The narrowed word is formed combinationally from the accumulator. It uses one of three rounding modes: truncation, round-to-nearest, or convergent rounding. A sticky flag records any overflow until the next clearing operation. A controller issues one tap per cycle and reads either the full accumulator or the rounded word.

Top module: `fxp_mac`

## Requirements
- R1: While rst_n is low at a clock edge, the accumulator and the overflow flag become zero. The rounded word then reads zero.
- R2: Operands a and b are signed fractions with OP_W bits (default 24, one sign bit and 23 fraction bits). Their product is the exact signed product times two, a 2*OP_W-bit value with 2*OP_W-1 fraction bits. The single case of most-negative times most-negative gives 2^(2*OP_W-1)-1.
- R3: At each clock edge with en high, acc becomes base + p when sub=0, or base - p when sub=1. Here p is the product of the operands sampled at that edge. base is zero when clr=1 and the previous acc when clr=0. With en low, acc holds its value.
- R4: acc is 2*OP_W+GUARD bits wide (default 56). If the sum in R3 falls outside this signed range, it wraps modulo 2^56 when sat_en=0. It clamps to 2^55-1 or -2^55 when sat_en=1.
- R5: res is formed from acc with its low OP_W bits removed, according to rnd_mode. 2'b00 takes the floor. 2'b01 adds half of the kept LSB and then takes the floor. 2'b10 does the same, except that an exact half goes to the even neighbour. 2'b11 behaves as 2'b00.
- R6: If the rounded value in R5 lies outside the signed OP_W-bit range, res is 0x7FFFFF (positive side) or 0x800000 (negative side) when sat_en=1. Otherwise res is the low OP_W bits of the rounded value.
- R7: At each clock edge with en=1 and clr=1, ovf becomes 0. At any other edge, ovf becomes set if it was set before, if the rounded value of the current acc under the current rnd_mode is out of range (R6), or if an enabled accumulate overflows (R4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Perform a multiply-accumulate this cycle |
| clr | input | 1 | Start from zero instead of the held accumulator |
| sub | input | 1 | Subtract the product instead of adding it |
| sat_en | input | 1 | Clamp on overflow instead of wrapping |
| rnd_mode | input | 2 | Store rounding: 00 floor, 01 nearest, 10 convergent, 11 floor |
| a | input | OP_W | Signed fractional operand |
| b | input | OP_W | Signed fractional operand |
| acc | output | 2*OP_W+GUARD | Full accumulator |
| res | output | OP_W | Rounded and range-limited data word |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The embedded properties are checked on every cycle. They cover four behaviours: acc holding while idle, the sticky flag staying set until a clearing operation, a saturating add of a non-negative product never turning a non-negative sum negative, and a convergent exact half never producing an odd word.

The exact arithmetic can only be shown by the bench's scenarios. This includes the realigned product and its single clamped case, and the bit-accurate results of all three rounding modes at exact halves of both signs. It also includes the wrap and clamp values after long runs of full-scale taps, and the point at which the flag rises.

// File: rtl/fxp_mac.sv
module fxp_mac #(
  parameter int OP_W  = 24,
  parameter int GUARD = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      clr,
  input  logic                      sub,
  input  logic                      sat_en,
  input  logic [1:0]                rnd_mode,
  input  logic signed [OP_W-1:0]    a,
  input  logic signed [OP_W-1:0]    b,
  output logic [2*OP_W+GUARD-1:0]   acc,
  output logic [OP_W-1:0]           res,
  output logic                      ovf
);
  localparam int PW = 2*OP_W;
  localparam int AW = PW + GUARD;
  localparam int QW = AW + 1 - OP_W;

  logic signed [AW-1:0] acc_q;
  logic                 ovf_q;

  logic signed [PW-1:0] raw, prod;
  logic                 both_min;
  assign raw      = a * b;
  assign both_min = (a == {1'b1, {(OP_W-1){1'b0}}}) && (b == {1'b1, {(OP_W-1){1'b0}}});
  assign prod     = both_min ? {1'b0, {(PW-1){1'b1}}} : (raw <<< 1);

  logic signed [AW:0] addend, base, sum;
  logic               acc_ovf;
  logic [AW-1:0]      acc_d;
  assign addend  = sub ? -{{(GUARD+1){prod[PW-1]}}, prod} : {{(GUARD+1){prod[PW-1]}}, prod};
  assign base    = clr ? '0 : {acc_q[AW-1], acc_q};
  assign sum     = base + addend;
  assign acc_ovf = sum[AW] != sum[AW-1];
  assign acc_d   = (acc_ovf && sat_en) ? (sum[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}})
                                       : sum[AW-1:0];

  logic [AW:0]   half, rsum;
  logic          rnd_on, tie;
  logic [QW-1:0] q;
  logic          st_ovf;
  assign rnd_on = (rnd_mode == 2'b01) || (rnd_mode == 2'b10);
  assign half   = (AW+1)'(1) << (OP_W-1);
  assign rsum   = {acc_q[AW-1], acc_q} + (rnd_on ? half : '0);
  assign tie    = (rnd_mode == 2'b10) && (acc_q[OP_W-1:0] == half[OP_W-1:0]);
  assign q      = {rsum[AW:OP_W+1], rsum[OP_W] & ~tie};
  assign st_ovf = !((&q[QW-1:OP_W-1]) || !(|q[QW-1:OP_W-1]));
  assign res    = (st_ovf && sat_en) ? (q[QW-1] ? {1'b1, {(OP_W-1){1'b0}}} : {1'b0, {(OP_W-1){1'b1}}})
                                     : q[OP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (en) acc_q <= acc_d;
      if (en && clr) ovf_q <= 1'b0;
      else           ovf_q <= ovf_q | st_ovf | (en & acc_ovf);
    end
  end

  assign acc = acc_q;
  assign ovf = ovf_q;

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_q));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr) |=> !ovf_q);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(en && clr)) |=> ovf_q);
  assert_sat_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sat_en && !clr && !sub && !acc_q[AW-1] && !prod[PW-1]) |=> !acc_q[AW-1]);
  assert_even_tie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tie && !st_ovf) |-> !res[0]);
endmodule

// File: tb/test_fxp_mac.sv
module test_fxp_mac;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, clr = 1'b0, sub = 1'b0, sat_en = 1'b0;
  logic [1:0] rnd_mode = 2'b00;
  logic signed [23:0] a = '0, b = '0;
  logic [55:0] acc;
  logic [23:0] res;
  logic ovf;
  int checks = 0, errors = 0;
  longint m_acc = 0;
  bit m_ovf = 0;
  bit done = 0;

  localparam longint AMAX = (64'sd1 <<< 55) - 1;
  localparam longint AMIN = -(64'sd1 <<< 55);

  always #5 clk = ~clk;

  fxp_mac i_fxp_mac (.clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .sub(sub), .sat_en(sat_en),
                     .rnd_mode(rnd_mode), .a(a), .b(b), .acc(acc), .res(res), .ovf(ovf));

  function automatic longint prod_of(longint x, longint y);
    longint p = x * y * 2;
    if (p == (64'sd1 <<< 47)) p = p - 1;
    return p;
  endfunction

  function automatic longint round_of(longint v, logic [1:0] m);
    longint fl = v >>> 24;
    longint lo = v & 64'hFFFFFF;
    if (m == 2'b01) return (v + 64'sh800000) >>> 24;
    if (m == 2'b10) begin
      if (lo == 64'sh800000) return (fl % 2 != 0) ? fl + 1 : fl;
      return (v + 64'sh800000) >>> 24;
    end
    return fl;
  endfunction

  function automatic bit out_rng(longint q);
    return (q > 8388607) || (q < -8388608);
  endfunction

  function automatic logic [23:0] res_of(longint v, logic [1:0] m, logic s);
    longint q = round_of(v, m);
    if (out_rng(q) && s) return (q < 0) ? 24'h800000 : 24'h7FFFFF;
    return q[23:0];
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit e, bit c, bit s, bit sat, logic [1:0] m, longint aa, longint bb);
    longint base, sum, nxt;
    bit ao, so;
    @(negedge clk);
    en = e; clr = c; sub = s; sat_en = sat; rnd_mode = m; a = aa[23:0]; b = bb[23:0];
    so = out_rng(round_of(m_acc, m));
    base = c ? 0 : m_acc;
    sum = s ? base - prod_of(aa, bb) : base + prod_of(aa, bb);
    ao = (sum > AMAX) || (sum < AMIN);
    nxt = ao ? (sat ? (sum < 0 ? AMIN : AMAX) : ((sum <<< 8) >>> 8)) : sum;
    @(posedge clk);
    if (e && c) m_ovf = 0; else m_ovf = m_ovf | so | (e && ao);
    if (e) m_acc = nxt;
    #2;
    chk(longint'($signed(acc)) == m_acc, "R2 R3 R4 acc", longint'($signed(acc)), m_acc);
    chk(res == res_of(m_acc, m, sat), "R5 R6 res", longint'(res), longint'(res_of(m_acc, m, sat)));
    chk(ovf == m_ovf, "R7 ovf", longint'(ovf), longint'(m_ovf));
  endtask

  function automatic longint pick();
    int r = $urandom_range(0, 9);
    if (r == 0) return -8388608;
    if (r == 1) return 8388607;
    if (r == 2) return 0;
    return longint'($signed(24'($urandom)));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    chk(acc == '0, "R1 acc", longint'(acc), 0);
    chk(ovf == 1'b0, "R1 ovf", longint'(ovf), 0);
    chk(res == '0, "R1 res", longint'(res), 0);
    @(negedge clk); rst_n = 1'b1;
    // R2: most negative squared clamps to largest product
    step(1, 1, 0, 1, 2'b00, -8388608, -8388608);
    step(1, 1, 0, 1, 2'b01, -8388608, -8388608);
    // R3 idle hold
    step(0, 0, 0, 1, 2'b00, 12345, 6789);
    // R5 exact halves of both signs in every mode
    for (int m = 0; m < 4; m++) begin
      step(1, 1, 0, 0, 2'(m), 2048, 2048);
      step(1, 1, 0, 0, 2'(m), 6144, 2048);
      step(1, 1, 1, 0, 2'(m), 2048, 2048);
      step(1, 1, 1, 0, 2'(m), 6144, 2048);
    end
    // R4 wrap then clamp after long full-scale runs
    for (int sat = 0; sat < 2; sat++) begin
      step(1, 1, 0, 1'(sat), 2'b00, -8388608, -8388608);
      for (int i = 0; i < 300; i++) step(1, 0, 0, 1'(sat), 2'b01, -8388608, -8388608);
      step(1, 1, 1, 1'(sat), 2'b00, -8388608, -8388608);
      for (int i = 0; i < 300; i++) step(1, 0, 1, 1'(sat), 2'b10, -8388608, -8388608);
    end
    // R7 clear drops the flag
    step(1, 1, 0, 0, 2'b00, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 7) != 0, $urandom_range(0, 15) == 0, 1'($urandom),
           1'($urandom), 2'($urandom), pick(), pick());
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule